// File: doc/BRIEF.md
# System Clock Source Switch with Deferred Completion

This block picks the source that drives the system clock. There are three candidates: the external crystal, the low-speed RC oscillator and the high-speed RC oscillator. Software selects one by writing a 3-bit code. Each source reports a ready indication and an enable. The block synchronizes these into per-source stable flags. A source that is disabled always shows a stable flag of 0.

A switch to a stable source takes effect at once. A switch to a source that is not yet stable is held pending. In that case the fail flag goes high and the old source stays active. When the pending target later shows a stable flag, the block completes the switch on its own and clears the fail flag.

The select field is write-protected. It accepts writes only after three key bytes have been written to a lock register in the required order. The glitch-free clock mux is not built here: the block drives a one-hot select that a mux elsewhere consumes.

Top module: `sysclk_switch`

## Requirements
- R1: After synchronous reset the select field reads 3'b111, the one-hot source select is 3'b100 (high-speed RC), the fail flag is 0, the lock is closed and all stable flags are 0.
- R2: The stable flag of source i (bit 0 crystal, bit 1 low-speed RC, bit 2 high-speed RC) equals the AND of its enable and ready inputs, delayed by SYNC_STAGES clock edges. It is 0 whenever the source is disabled.
- R3: Writing KEY0 (0x59), KEY1 (0x16) and KEY2 (0x88) to LOCK_ADDR as consecutive lock-register writes opens the protection, and the unlocked output goes to 1.
- R4: A lock-register write that does not carry the expected next key byte returns the sequence to its start. That breaking byte does not count as a first key byte. Any lock-register write while open closes the protection.
- R5: A write to SEL_ADDR while the protection is closed changes neither the select field nor the fail flag.
- R6: The codes are 3'b000 (crystal, select bit 0), 3'b011 (low-speed RC, select bit 1) and 3'b111 (high-speed RC, select bit 2). An unlocked write of a code whose target stable flag is 1 updates the field and the select one cycle after the write and clears the fail flag. Whenever the fail flag is 0, the select matches the field.
- R7: An unlocked write of a valid code whose target stable flag is 0 updates the field and sets the fail flag. The one-hot select keeps the old source.
- R8: While the fail flag is 1, the edge after the pending target's stable flag reads 1 switches the select to that target and clears the fail flag.
- R9: Codes 3'b001, 3'b010, 3'b100, 3'b101 and 3'b110 are reserved. Writing one leaves the field, the select and the fail flag unchanged, including while a switch is pending.
- R10: A valid write while a switch is pending replaces the pending target. Completion then depends only on the new target's stable flag.
- R11: Exactly one bit of the one-hot select is set at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address (LOCK_ADDR or SEL_ADDR) |
| wr_data | input | DATA_W | Write data; bits 2:0 carry the select code |
| src_en | input | 3 | Per-source enable (bit 0 crystal, 1 low RC, 2 high RC) |
| src_rdy | input | 3 | Per-source ready indication from the oscillator model |
| stable_flags | output | 3 | Synchronized per-source stable flags |
| sel_field | output | 3 | Readback of the accepted select code |
| src_sel | output | 3 | One-hot source select for the clock mux |
| switch_fail | output | 1 | Switch-fail flag; 1 while a switch is pending |
| unlocked | output | 1 | Protection open |

## Verification
The bench targets pending switches. It replaces a pending target with a new one, writes a reserved code while a switch is pending and checks that the pending switch still completes, and waits for completion only once the target becomes stable. A design that aborted rather than deferred would leave the select on the old source after the target stabilised. A design that kept the first pending target would switch to the wrong source.

On the lock, the bench feeds a broken key order, then a second key byte right after the break. It also checks that a write while open closes the protection. A lock that resynchronised on any key byte, or stayed open after use, would let a later select write through.

The stable-flag latency is sampled on the exact edge it should appear, and a disabled-but-ready source must read 0.

// File: rtl/sysclk_switch_pkg.sv
package sysclk_switch_pkg;

  localparam int NSRC = 3;

  localparam logic [2:0] CODE_XTAL = 3'b000;
  localparam logic [2:0] CODE_LRC  = 3'b011;
  localparam logic [2:0] CODE_HRC  = 3'b111;

  typedef enum logic [1:0] {
    LK_IDLE,
    LK_KEY1,
    LK_KEY2,
    LK_OPEN
  } lock_state_t;

  // Map a select code to the one-hot source vector; reserved codes give 0.
  function automatic logic [NSRC-1:0] code_to_onehot(input logic [2:0] code);
    logic [NSRC-1:0] oh;
    case (code)
      CODE_XTAL: oh = 3'b001;
      CODE_LRC:  oh = 3'b010;
      CODE_HRC:  oh = 3'b100;
      default:   oh = 3'b000;
    endcase
    return oh;
  endfunction

endpackage

// File: rtl/sysclk_stable_sync.sv
module sysclk_stable_sync #(
  parameter int NSRC   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_rdy,
  output logic [NSRC-1:0] stb
);

  logic [NSRC-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= src_en & src_rdy;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[k] <= '0;
      else     pipe[k] <= pipe[k-1];
    end
  end

  assign stb = pipe[STAGES-1];

endmodule

// File: rtl/sysclk_unlock.sv
module sysclk_unlock
  import sysclk_switch_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = '0,
  parameter logic [DATA_W-1:0] KEY0      = 8'h59,
  parameter logic [DATA_W-1:0] KEY1      = 8'h16,
  parameter logic [DATA_W-1:0] KEY2      = 8'h88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              open
);

  lock_state_t st_q, st_d;
  logic        lock_wr;

  assign lock_wr = wr_en && (wr_addr == LOCK_ADDR);

  always_comb begin
    st_d = st_q;
    if (lock_wr) begin
      case (st_q)
        LK_IDLE: st_d = (wr_data == KEY0) ? LK_KEY1 : LK_IDLE;
        LK_KEY1: st_d = (wr_data == KEY1) ? LK_KEY2 : LK_IDLE;
        LK_KEY2: st_d = (wr_data == KEY2) ? LK_OPEN : LK_IDLE;
        default: st_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= LK_IDLE;
      open <= 1'b0;
    end else begin
      st_q <= st_d;
      open <= (st_d == LK_OPEN);
    end
  end

endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl
  import sysclk_switch_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_wr,
  input  logic [2:0]      wr_code,
  input  logic [NSRC-1:0] stb,
  output logic [2:0]      field_q,
  output logic [NSRC-1:0] active_q,
  output logic            fail_q
);

  logic [NSRC-1:0] wr_oh;
  logic [NSRC-1:0] pend_oh;
  logic            wr_valid;
  logic            wr_ready;
  logic            pend_ready;

  assign wr_oh      = code_to_onehot(wr_code);
  assign pend_oh    = code_to_onehot(field_q);
  assign wr_valid   = |wr_oh;
  assign wr_ready   = |(wr_oh & stb);
  assign pend_ready = fail_q && |(pend_oh & stb);

  // The fail flag doubles as the pending marker; the pending target is
  // the accepted field itself, so a new write replaces it directly.
  always_ff @(posedge clk) begin
    if (rst) begin
      field_q  <= CODE_HRC;
      active_q <= code_to_onehot(CODE_HRC);
      fail_q   <= 1'b0;
    end else if (sel_wr && wr_valid) begin
      field_q <= wr_code;
      if (wr_ready) begin
        active_q <= wr_oh;
        fail_q   <= 1'b0;
      end else begin
        fail_q   <= 1'b1;
      end
    end else if (pend_ready) begin
      active_q <= pend_oh;
      fail_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_switch_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LOCK_ADDR   = 4'h0,
  parameter logic [ADDR_W-1:0] SEL_ADDR    = 4'h4,
  parameter logic [DATA_W-1:0] KEY0        = 8'h59,
  parameter logic [DATA_W-1:0] KEY1        = 8'h16,
  parameter logic [DATA_W-1:0] KEY2        = 8'h88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        src_en,
  input  logic [2:0]        src_rdy,
  output logic [2:0]        stable_flags,
  output logic [2:0]        sel_field,
  output logic [2:0]        src_sel,
  output logic              switch_fail,
  output logic              unlocked
);

  logic sel_wr;

  sysclk_stable_sync #(
    .NSRC   (NSRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .src_en  (src_en),
    .src_rdy (src_rdy),
    .stb     (stable_flags)
  );

  sysclk_unlock #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LOCK_ADDR (LOCK_ADDR),
    .KEY0      (KEY0),
    .KEY1      (KEY1),
    .KEY2      (KEY2)
  ) u_unlock (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .open    (unlocked)
  );

  assign sel_wr = wr_en && (wr_addr == SEL_ADDR) && unlocked;

  sysclk_switch_ctrl #(
    .NSRC (NSRC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sel_wr   (sel_wr),
    .wr_code  (wr_data[2:0]),
    .stb      (stable_flags),
    .field_q  (sel_field),
    .active_q (src_sel),
    .fail_q   (switch_fail)
  );

endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk
  import sysclk_switch_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LOCK_ADDR   = 4'h0,
  parameter logic [ADDR_W-1:0] SEL_ADDR    = 4'h4,
  parameter logic [DATA_W-1:0] KEY0        = 8'h59,
  parameter logic [DATA_W-1:0] KEY1        = 8'h16,
  parameter logic [DATA_W-1:0] KEY2        = 8'h88
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [2:0]        src_en,
  input logic [2:0]        src_rdy,
  input logic [2:0]        stable_flags,
  input logic [2:0]        sel_field,
  input logic [2:0]        src_sel,
  input logic              switch_fail,
  input logic              unlocked
);

  AST_SELECT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(src_sel) == 1);  // R11

  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == SEL_ADDR && !unlocked) |=> $stable(sel_field));  // R5

  AST_FAIL_KEEPS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(switch_fail) |-> $stable(src_sel));  // R7

  AST_NO_FAIL_MATCHES_FIELD: assert property (@(posedge clk) disable iff (rst)
    !switch_fail |-> (src_sel == code_to_onehot(sel_field)));  // R6

  AST_COMPLETION_LANDS_ON_TARGET: assert property (@(posedge clk) disable iff (rst)
    $fell(switch_fail) |-> (src_sel == code_to_onehot(sel_field)));  // R8

  AST_WRITE_WHILE_OPEN_RELOCKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == LOCK_ADDR && unlocked) |=> !unlocked);  // R4

endmodule

bind sysclk_switch sysclk_switch_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .SYNC_STAGES (SYNC_STAGES),
  .LOCK_ADDR   (LOCK_ADDR),
  .SEL_ADDR    (SEL_ADDR),
  .KEY0        (KEY0),
  .KEY1        (KEY1),
  .KEY2        (KEY2)
) u_chk (.*);

// File: tb/test_sysclk_switch.sv
module test_sysclk_switch;

  localparam int          ADDR_W   = 4;
  localparam int          DATA_W   = 8;
  localparam int          SYNC     = 2;
  localparam logic [3:0]  A_LOCK   = 4'h0;
  localparam logic [3:0]  A_SEL    = 4'h4;

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] ok;
    logic       wr;
    logic       sel;   // 1: select register, 0: lock register
    logic [7:0] d;
    logic [2:0] oh;
    logic [2:0] fld;
    logic       fail;
    logic       open;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{4'd5,  3'b111, 1'b1, 1'b1, 8'h00, 3'b100, 3'b111, 1'b0, 1'b0}, // R5 locked write
    '{4'd3,  3'b111, 1'b1, 1'b0, 8'h59, 3'b100, 3'b111, 1'b0, 1'b0}, // R3
    '{4'd3,  3'b111, 1'b1, 1'b0, 8'h16, 3'b100, 3'b111, 1'b0, 1'b0}, // R3
    '{4'd3,  3'b111, 1'b1, 1'b0, 8'h88, 3'b100, 3'b111, 1'b0, 1'b1}, // R3 open
    '{4'd6,  3'b111, 1'b1, 1'b1, 8'h00, 3'b001, 3'b000, 1'b0, 1'b1}, // R6 crystal
    '{4'd6,  3'b111, 1'b1, 1'b1, 8'h03, 3'b010, 3'b011, 1'b0, 1'b1}, // R6 low RC
    '{4'd9,  3'b111, 1'b1, 1'b1, 8'h01, 3'b010, 3'b011, 1'b0, 1'b1}, // R9
    '{4'd9,  3'b111, 1'b1, 1'b1, 8'h02, 3'b010, 3'b011, 1'b0, 1'b1}, // R9
    '{4'd7,  3'b010, 1'b1, 1'b1, 8'h07, 3'b010, 3'b111, 1'b1, 1'b1}, // R7
    '{4'd10, 3'b010, 1'b1, 1'b1, 8'h00, 3'b010, 3'b000, 1'b1, 1'b1}, // R10
    '{4'd8,  3'b011, 1'b0, 1'b1, 8'h00, 3'b001, 3'b000, 1'b0, 1'b1}, // R8
    '{4'd9,  3'b011, 1'b1, 1'b1, 8'h05, 3'b001, 3'b000, 1'b0, 1'b1}, // R9
    '{4'd4,  3'b011, 1'b1, 1'b0, 8'h00, 3'b001, 3'b000, 1'b0, 1'b0}, // R4 relock
    '{4'd4,  3'b011, 1'b1, 1'b0, 8'h59, 3'b001, 3'b000, 1'b0, 1'b0}, // R4
    '{4'd4,  3'b011, 1'b1, 1'b0, 8'h88, 3'b001, 3'b000, 1'b0, 1'b0}, // R4 break
    '{4'd4,  3'b011, 1'b1, 1'b0, 8'h16, 3'b001, 3'b000, 1'b0, 1'b0}, // R4
    '{4'd4,  3'b011, 1'b1, 1'b0, 8'h88, 3'b001, 3'b000, 1'b0, 1'b0}, // R4 still shut
    '{4'd5,  3'b011, 1'b1, 1'b1, 8'h07, 3'b001, 3'b000, 1'b0, 1'b0}, // R5
    '{4'd3,  3'b011, 1'b1, 1'b0, 8'h59, 3'b001, 3'b000, 1'b0, 1'b0}, // R3
    '{4'd3,  3'b011, 1'b1, 1'b0, 8'h16, 3'b001, 3'b000, 1'b0, 1'b0}, // R3
    '{4'd3,  3'b011, 1'b1, 1'b0, 8'h88, 3'b001, 3'b000, 1'b0, 1'b1}, // R3
    '{4'd6,  3'b111, 1'b1, 1'b1, 8'h07, 3'b100, 3'b111, 1'b0, 1'b1}, // R6 high RC
    '{4'd7,  3'b001, 1'b1, 1'b1, 8'h03, 3'b100, 3'b011, 1'b1, 1'b1}, // R7
    '{4'd9,  3'b001, 1'b1, 1'b1, 8'h06, 3'b100, 3'b011, 1'b1, 1'b1}, // R9 while pending
    '{4'd8,  3'b011, 1'b0, 1'b1, 8'h00, 3'b010, 3'b011, 1'b0, 1'b1}  // R8
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [2:0]        src_en;
  logic [2:0]        src_rdy;
  logic [2:0]        stable_flags;
  logic [2:0]        sel_field;
  logic [2:0]        src_sel;
  logic              switch_fail;
  logic              unlocked;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sysclk_switch #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC),
    .LOCK_ADDR   (A_LOCK),
    .SEL_ADDR    (A_SEL)
  ) i_sysclk_switch (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .src_en       (src_en),
    .src_rdy      (src_rdy),
    .stable_flags (stable_flags),
    .sel_field    (sel_field),
    .src_sel      (src_sel),
    .switch_fail  (switch_fail),
    .unlocked     (unlocked)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_reset_state();
    check("R1 src_sel",      {5'd0, src_sel},      8'h04);
    check("R1 sel_field",    {5'd0, sel_field},    8'h07);
    check("R1 switch_fail",  {7'd0, switch_fail},  8'h00);
    check("R1 unlocked",     {7'd0, unlocked},     8'h00);
    check("R1 stable_flags", {5'd0, stable_flags}, 8'h00);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    src_en = '0; src_rdy = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();

    for (int i = 0; i < NV; i++) begin
      src_en  = TBL[i].ok;
      src_rdy = TBL[i].ok;
      repeat (SYNC + 1) @(negedge clk);
      if (TBL[i].wr) begin
        wr_en   = 1'b1;
        wr_addr = TBL[i].sel ? A_SEL : A_LOCK;
        wr_data = TBL[i].d;
      end
      @(negedge clk);
      wr_en = 1'b0;
      check($sformatf("R%0d row %0d src_sel", TBL[i].req, i),     {5'd0, src_sel},      {5'd0, TBL[i].oh});
      check($sformatf("R%0d row %0d sel_field", TBL[i].req, i),   {5'd0, sel_field},    {5'd0, TBL[i].fld});
      check($sformatf("R%0d row %0d switch_fail", TBL[i].req, i), {7'd0, switch_fail},  {7'd0, TBL[i].fail});
      check($sformatf("R%0d row %0d unlocked", TBL[i].req, i),    {7'd0, unlocked},     {7'd0, TBL[i].open});
      check($sformatf("R2 row %0d stable_flags", i),              {5'd0, stable_flags}, {5'd0, TBL[i].ok});
    end

    // R2: ready but disabled sources read 0
    src_en = 3'b000; src_rdy = 3'b111;
    repeat (SYNC + 1) @(negedge clk);
    check("R2 disabled reads 0", {5'd0, stable_flags}, 8'h00);
    // R2: latency is exactly SYNC edges
    src_en = 3'b111;
    repeat (SYNC - 1) @(negedge clk);
    check("R2 before latency", {5'd0, stable_flags}, 8'h00);
    @(negedge clk);
    check("R2 at latency", {5'd0, stable_flags}, 8'h07);

    // R1: reset in mid-run restores the reset state
    rst = 1'b1;
    @(negedge clk);
    src_en = '0; src_rdy = '0;
    repeat (SYNC) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule